// File: doc/BRIEF.md
# Single-clock FIFO with read-position rewind and selectable output timing

This block is a 36-bit, single-clock FIFO controller wrapped around a dual-port storage array. Words enter when the write enable and write chip select are both high. A read request is the read enable qualified by the read chip select, both taken at the clock edge. Three status outputs are provided: a read-side flag, a write-side flag and a half-full flag.

Two output timing modes exist. In standard mode the read-side flag signals "empty", the write-side flag signals "full", and a word moves onto `rd_data` only on the edge that accepts a read. In fall-through mode the read-side flag signals "a valid word is on `rd_data`", the write-side flag signals "room for a write", and the head word is visible without any read request. The mode is taken from `fwft_sel` in every cycle that master reset is held, and it is kept until the next master reset.

Software can hold `mark` high to pin the current read position. While the mark is held, the write side may not overwrite anything from that position onward. A `retx` pulse rewinds the read pointer to the marked position, so the words from there on can be read again. Partial reset empties the FIFO and drops the mark but keeps the output mode.

Top module: `rewind_fifo`

## Requirements
- R1: In a cycle with `rst_n` low, the next edge empties the FIFO, clears the mark and sets `rd_data` to 0. The same edge loads the output mode from `fwft_sel` (0 = standard, 1 = fall-through). The mode does not change while `rst_n` stays high.
- R2: A write is accepted when `wr_en` and `wr_cs` are both 1 and the FIFO is not full. Accepted words are read back in the order they were written. A write with `wr_cs` at 0 is ignored.
- R3: A write attempted while full is ignored. No stored word is overwritten and the flags do not change.
- R4: A read request is `rd_en` and `rd_cs` both at 1. A request while empty, or with `rd_cs` at 0, does not move the read position.
- R5: Standard mode: `flag_rd` is 1 exactly when the FIFO is empty and `flag_wr` is 1 exactly when it is full. `rd_data` takes the head word on the edge that accepts a read and holds its value otherwise.
- R6: Fall-through mode: `flag_rd` is 1 exactly when at least one word is stored and `flag_wr` is 1 exactly when not full. `rd_data` shows the head word, available right after the edge that wrote it, and shows 0 while empty.
- R7: `half_full` is 1 exactly when the number of stored words is greater than DEPTH/2.
- R8: When a read and a write are both accepted on one edge, the stored word count is unchanged.
- R9: On the first edge with `mark` at 1, the current read position is recorded, taken before any read on that edge. While `mark` stays 1, the FIFO is full once DEPTH words have been written since the recorded position. When `mark` is 0 the mark is released.
- R10: A `retx` pulse while the mark is held sets the read position to the marked position on the next edge, and it takes priority over a read request on that edge. In fall-through mode the marked word is on `rd_data` after that edge. A `retx` with no mark held is ignored.
- R11: In a cycle with `part_rst_n` low, the next edge empties the FIFO, clears the mark and sets `rd_data` to 0, and the output mode is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Master reset, synchronous, active low |
| part_rst_n | input | 1 | Partial reset, synchronous, active low |
| fwft_sel | input | 1 | Output mode sampled during master reset: 1 = fall-through |
| wr_en | input | 1 | Write enable |
| wr_cs | input | 1 | Write chip select |
| wr_data | input | 36 | Write word |
| rd_en | input | 1 | Read enable |
| rd_cs | input | 1 | Read chip select |
| mark | input | 1 | Hold high to pin the read position |
| retx | input | 1 | Rewind the read position to the mark |
| rd_data | output | 36 | Read word |
| flag_rd | output | 1 | Empty (standard) or output ready (fall-through) |
| flag_wr | output | 1 | Full (standard) or input ready (fall-through) |
| half_full | output | 1 | More than half the depth is stored |

## Verification
A wrong write or read pointer shows up on the flags within one edge. The same wrong pointer shows up on `rd_data` at the next accepted read in standard mode, and at once in fall-through mode, because there the head word is visible all the time. A mark pointer recorded at the wrong position only becomes visible later: either as a full flag at the wrong fill level while the mark is held, or as a wrong word right after a retransmit. The bench therefore holds marks across long fill and drain runs and compares every output on every cycle.

// File: rtl/frt_pkg.sv
package frt_pkg;
  typedef enum logic {
    OUT_STD  = 1'b0,
    OUT_FWFT = 1'b1
  } out_mode_e;
endpackage

// File: rtl/frt_ram.sv
module frt_ram #(
  parameter int W  = 36,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/frt_ctrl.sv
module frt_ctrl #(
  parameter int AW = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        part_rst_n,
  input  logic        wr_req,
  input  logic        rd_req,
  input  logic        mark,
  input  logic        retx,
  output logic [AW:0] wptr,
  output logic [AW:0] rptr,
  output logic [AW:0] mark_ptr,
  output logic [AW:0] count,
  output logic        mark_act,
  output logic        wr_fire,
  output logic        rd_fire,
  output logic        rt_fire,
  output logic        is_empty,
  output logic        is_full,
  output logic        is_half
);
  localparam int          DEPTH   = 1 << AW;
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALF_V  = (AW+1)'(DEPTH / 2);

  // distance from tail to head, wrap handled by the extra pointer bit
  function automatic logic [AW:0] gap(input logic [AW:0] head, input logic [AW:0] tail);
    return head - tail;
  endfunction

  function automatic logic over_half(input logic [AW:0] n);
    return n > HALF_V;
  endfunction

  logic [AW:0] full_ref;
  logic        clr;

  assign clr      = ~rst_n | ~part_rst_n;
  assign full_ref = mark_act ? mark_ptr : rptr;
  assign count    = gap(wptr, rptr);
  assign is_empty = (count == '0);
  assign is_full  = (gap(wptr, full_ref) == DEPTH_V);
  assign is_half  = over_half(count);

  assign wr_fire  = wr_req & ~is_full;
  assign rt_fire  = retx & mark_act;
  assign rd_fire  = rd_req & ~is_empty & ~rt_fire;

  always_ff @(posedge clk) begin
    if (clr) begin
      wptr     <= '0;
      rptr     <= '0;
      mark_ptr <= '0;
      mark_act <= 1'b0;
    end else begin
      if (wr_fire) wptr <= wptr + 1'b1;
      if (rt_fire)      rptr <= mark_ptr;
      else if (rd_fire) rptr <= rptr + 1'b1;
      if (mark && !mark_act) mark_ptr <= rptr;
      mark_act <= mark;
    end
  end
endmodule

// File: rtl/frt_out.sv
module frt_out
  import frt_pkg::*;
#(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         part_rst_n,
  input  out_mode_e    mode,
  input  logic         rd_fire,
  input  logic [W-1:0] ram_q,
  input  logic         is_empty,
  input  logic         is_full,
  output logic [W-1:0] rd_data,
  output logic         flag_rd,
  output logic         flag_wr
);
  logic [W-1:0] std_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !part_rst_n) std_q <= '0;
    else if (rd_fire && mode == OUT_STD) std_q <= ram_q;
  end

  always_comb begin
    if (mode == OUT_FWFT) begin
      rd_data = is_empty ? '0 : ram_q;
      flag_rd = ~is_empty;
      flag_wr = ~is_full;
    end else begin
      rd_data = std_q;
      flag_rd = is_empty;
      flag_wr = is_full;
    end
  end
endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo
  import frt_pkg::*;
#(
  parameter int W  = 36,
  parameter int AW = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         part_rst_n,
  input  logic         fwft_sel,
  input  logic         wr_en,
  input  logic         wr_cs,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  input  logic         rd_cs,
  input  logic         mark,
  input  logic         retx,
  output logic [W-1:0] rd_data,
  output logic         flag_rd,
  output logic         flag_wr,
  output logic         half_full
);
  out_mode_e   mode_q;
  logic [AW:0] wptr, rptr, mark_ptr, count;
  logic        mark_act, wr_fire, rd_fire, rt_fire;
  logic        is_empty, is_full, is_half;
  logic [W-1:0] ram_q;

  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= fwft_sel ? OUT_FWFT : OUT_STD;
  end

  frt_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .part_rst_n(part_rst_n),
    .wr_req(wr_en & wr_cs), .rd_req(rd_en & rd_cs),
    .mark(mark), .retx(retx),
    .wptr(wptr), .rptr(rptr), .mark_ptr(mark_ptr), .count(count),
    .mark_act(mark_act), .wr_fire(wr_fire), .rd_fire(rd_fire), .rt_fire(rt_fire),
    .is_empty(is_empty), .is_full(is_full), .is_half(is_half)
  );

  frt_ram #(.W(W), .AW(AW)) u_ram (
    .clk(clk), .we(wr_fire), .waddr(wptr[AW-1:0]), .wdata(wr_data),
    .raddr(rptr[AW-1:0]), .rdata(ram_q)
  );

  frt_out #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .part_rst_n(part_rst_n), .mode(mode_q),
    .rd_fire(rd_fire), .ram_q(ram_q), .is_empty(is_empty), .is_full(is_full),
    .rd_data(rd_data), .flag_rd(flag_rd), .flag_wr(flag_wr)
  );

  assign half_full = is_half;
endmodule

// File: rtl/frt_chk.sv
module frt_chk
  import frt_pkg::*;
#(
  parameter int AW = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        part_rst_n,
  input out_mode_e   mode_q,
  input logic [AW:0] wptr,
  input logic [AW:0] rptr,
  input logic [AW:0] mark_ptr,
  input logic [AW:0] count,
  input logic        mark_act,
  input logic        wr_fire,
  input logic        rd_fire,
  input logic        rt_fire,
  input logic        is_empty,
  input logic        is_full
);
  localparam logic [AW:0] DEPTH_V = (AW+1)'(1 << AW);

  // R1: output mode frozen outside master reset
  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(mode_q));

  // R3: full blocks the write pointer
  p_full_blocks_wr_r3: assert property (@(posedge clk) disable iff (!rst_n || !part_rst_n)
    is_full |=> $stable(wptr));

  // R4: empty without rewind blocks the read pointer
  p_empty_blocks_rd_r4: assert property (@(posedge clk) disable iff (!rst_n || !part_rst_n)
    (is_empty && !rt_fire) |=> $stable(rptr));

  // R8: simultaneous read and write keep the count
  p_rw_count_r8: assert property (@(posedge clk) disable iff (!rst_n || !part_rst_n)
    (wr_fire && rd_fire) |=> (count == $past(count)));

  // R9: writes never run past the marked (or live) read position
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n || !part_rst_n)
    ((wptr - (mark_act ? mark_ptr : rptr)) <= DEPTH_V));

  // R10: rewind lands on the recorded position
  p_rt_lands_r10: assert property (@(posedge clk) disable iff (!rst_n || !part_rst_n)
    rt_fire |=> (rptr == $past(mark_ptr)));
endmodule

bind rewind_fifo frt_chk #(.AW(AW)) u_frt_chk (
  .clk(clk), .rst_n(rst_n), .part_rst_n(part_rst_n), .mode_q(mode_q),
  .wptr(wptr), .rptr(rptr), .mark_ptr(mark_ptr), .count(count),
  .mark_act(mark_act), .wr_fire(wr_fire), .rd_fire(rd_fire), .rt_fire(rt_fire),
  .is_empty(is_empty), .is_full(is_full)
);

// File: tb/test_rewind_fifo.sv
module test_rewind_fifo;
  localparam int W = 36, AW = 4, DEPTH = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, part_rst_n = 1'b1, fwft_sel = 1'b0;
  logic wr_en = 1'b0, wr_cs = 1'b0, rd_en = 1'b0, rd_cs = 1'b0, mark = 1'b0, retx = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic flag_rd, flag_wr, half_full;

  rewind_fifo #(.W(W), .AW(AW)) i_rewind_fifo (
    .clk(clk), .rst_n(rst_n), .part_rst_n(part_rst_n), .fwft_sel(fwft_sel),
    .wr_en(wr_en), .wr_cs(wr_cs), .wr_data(wr_data), .rd_en(rd_en), .rd_cs(rd_cs),
    .mark(mark), .retx(retx), .rd_data(rd_data), .flag_rd(flag_rd),
    .flag_wr(flag_wr), .half_full(half_full)
  );

  int vectors = 0, errors = 0, seq = 0;
  string req = "R1";
  bit done = 1'b0;

  // reference model
  bit m_fwft = 1'b0, mact = 1'b0;
  int wp = 0, rp = 0, mp = 0;
  logic [W-1:0] mm [DEPTH];
  logic [W-1:0] sq = '0;

  task automatic chk(input string nm, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, nm, act, exp);
    end
  endtask

  task automatic model_edge();
    bit full, empty, wf, rf, rtf;
    if (!rst_n || !part_rst_n) begin
      wp = 0; rp = 0; mp = 0; mact = 1'b0; sq = '0;
      if (!rst_n) m_fwft = fwft_sel;
    end else begin
      full  = (wp - (mact ? mp : rp)) == DEPTH;
      empty = (wp == rp);
      wf  = wr_en && wr_cs && !full;
      rtf = retx && mact;
      rf  = rd_en && rd_cs && !empty && !rtf;
      if (mark && !mact) mp = rp;
      mact = mark;
      if (wf) begin mm[wp % DEPTH] = wr_data; wp++; end
      if (rtf) rp = mp;
      else if (rf) begin
        if (!m_fwft) sq = mm[rp % DEPTH];
        rp++;
      end
    end
  endtask

  task automatic compare();
    int cnt;
    bit empty, full;
    logic [W-1:0] ed;
    cnt   = wp - rp;
    empty = (cnt == 0);
    full  = (wp - (mact ? mp : rp)) == DEPTH;
    ed    = m_fwft ? (empty ? '0 : mm[rp % DEPTH]) : sq;
    chk("flag_rd", W'(flag_rd), W'(m_fwft ? !empty : empty));
    chk("flag_wr", W'(flag_wr), W'(m_fwft ? !full : full));
    chk("half_full", W'(half_full), W'(cnt > DEPTH / 2));
    chk("rd_data", rd_data, ed);
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    #5;
    compare();
  endtask

  task automatic wr1();
    seq++;
    wr_data = W'(seq * 32'h9E37_79B1) ^ {W'(seq), 4'h0};
    wr_en = 1'b1; wr_cs = 1'b1;
    tick();
    wr_en = 1'b0; wr_cs = 1'b0;
  endtask

  task automatic rd1();
    rd_en = 1'b1; rd_cs = 1'b1;
    tick();
    rd_en = 1'b0; rd_cs = 1'b0;
  endtask

  task automatic master_reset(input logic sel);
    fwft_sel = sel; rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1; fwft_sel = ~sel;
    tick();
  endtask

  task automatic sweep(input int n, input logic [15:0] seed);
    logic [15:0] lf;
    lf = seed;
    for (int i = 0; i < n; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      seq++;
      wr_data = W'(seq * 32'h01F3_A5C7);
      wr_en = lf[0]; wr_cs = lf[1] | lf[2];
      rd_en = lf[3]; rd_cs = lf[4] | lf[5];
      if (lf[8:6] == 3'd0) mark = ~mark;
      retx = (lf[11:9] == 3'd0);
      part_rst_n = (lf[15:12] != 4'hF) || (i % 7 != 0);
      tick();
    end
    wr_en = 0; wr_cs = 0; rd_en = 0; rd_cs = 0; mark = 0; retx = 0; part_rst_n = 1;
    tick();
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL %s watchdog: actual hung expected finished", req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset into standard mode
    req = "R1";
    master_reset(1'b0);
    tick();

    // R2 and R7: fill to full, half flag rises past DEPTH/2
    req = "R7";
    for (int i = 0; i < DEPTH; i++) wr1();
    // R3: writes while full ignored
    req = "R3";
    wr1(); wr1();
    // R5: drain in order, standard data timing
    req = "R5";
    for (int i = 0; i < DEPTH; i++) begin rd1(); tick(); end
    // R4: reads while empty ignored
    req = "R4";
    rd1(); rd1();
    req = "R2";
    wr1(); wr1(); wr1();
    wr_en = 1'b1; wr_cs = 1'b0; wr_data = 36'hDEAD; tick(); wr_en = 1'b0;
    req = "R4";
    rd_en = 1'b1; rd_cs = 1'b0; tick(); tick(); rd_en = 1'b0;
    // R8: simultaneous read and write
    req = "R8";
    for (int i = 0; i < 5; i++) begin
      seq++; wr_data = W'(seq) ^ 36'hA5A5_0000_0;
      wr_en = 1; wr_cs = 1; rd_en = 1; rd_cs = 1; tick();
    end
    wr_en = 0; wr_cs = 0; rd_en = 0; rd_cs = 0;

    // R11: partial reset keeps standard mode
    req = "R11";
    part_rst_n = 1'b0; fwft_sel = 1'b1; tick(); part_rst_n = 1'b1; tick();

    // R9: mark limits the fill
    req = "R9";
    for (int i = 0; i < 6; i++) wr1();
    mark = 1'b1; tick();
    for (int i = 0; i < 6; i++) rd1();
    for (int i = 0; i < 12; i++) wr1();
    // R10: rewind beats a read request
    req = "R10";
    retx = 1'b1; rd_en = 1'b1; rd_cs = 1'b1; tick();
    retx = 1'b0; rd_en = 1'b0; rd_cs = 1'b0;
    for (int i = 0; i < DEPTH; i++) rd1();
    mark = 1'b0; tick();
    retx = 1'b1; tick(); retx = 1'b0; tick();

    // R1: master reset into fall-through mode
    req = "R1";
    master_reset(1'b1);
    // R6: word falls through without a read request
    req = "R6";
    wr1(); tick();
    for (int i = 0; i < 5; i++) wr1();
    rd1(); rd1();
    // R10: rewind in fall-through mode
    req = "R10";
    mark = 1'b1; tick();
    rd1(); rd1(); rd1();
    retx = 1'b1; tick(); retx = 1'b0; tick();
    mark = 1'b0; tick();
    req = "R6";
    for (int i = 0; i < DEPTH + 2; i++) wr1();
    for (int i = 0; i < DEPTH + 2; i++) rd1();
    // R11: partial reset keeps fall-through mode
    req = "R11";
    wr1(); part_rst_n = 1'b0; fwft_sel = 1'b0; tick(); part_rst_n = 1'b1; tick(); wr1();

    // near-exhaustive mixed sweeps in both modes
    req = "R2";
    sweep(3000, 16'hACE1);
    req = "R9";
    master_reset(1'b0);
    sweep(3000, 16'h1D2B);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule